// File: doc/BRIEF.md
# Shift-and-Add Execution Unit

This unit computes one 64-bit result per accepted operation: it shifts the second operand left by a distance of one to four bit positions, drops the bits shifted out at the top, and adds the first operand. The sum wraps modulo 2^64, and the carry out of the adder is lost. A two-bit variant code sets how the second operand is prepared before the shift. In the full-width variant it is used as it is. The word variants keep only its low 32 bits and widen them back to 64 bits, either by sign extension or by zero extension.

The scheduler presents one operation per cycle, with a valid strobe. The result appears in a register one cycle later. When the operation asks for a recorded form, the unit also produces a four-bit condition field and a write enable in the same cycle as the result. The condition field holds a signed compare of the result against zero, followed by a copy of the incoming summary-overflow bit.

Top module: `shadd_unit`

## Requirements
- R1: In the full-width variant (variant code 0), the result is `(op_b << (sh_imm + 1)) + op_a` truncated to 64 bits. The shift distance is therefore 1, 2, 3 or 4 for `sh_imm` values 0 to 3.
- R2: The addition wraps modulo 2^64, and no carry is reported. For example, `op_a` = all ones, `op_b` = 1 and `sh_imm` = 0 give a result of 1.
- R3: In the signed-word variant (variant code 1), the shifted operand is `op_b[31:0]` sign-extended from bit 31 to 64 bits. The upper half of `op_b` has no effect.
- R4: In the unsigned-word variant (variant code 2), the shifted operand is `op_b[31:0]` zero-extended to 64 bits.
- R5: Variant code 3 behaves exactly like the full-width variant.
- R6: `res_valid` is high in the cycle after the cycle in which `in_valid` is sampled high, and low otherwise. `res_data` changes only after an accepted operation and holds its value otherwise.
- R7: `cr_we` is high one cycle after an accepted operation that has `rec_en` high, and low otherwise. `cr_val` holds its value whenever no update occurs.
- R8: When the condition field is updated, the bits are `cr_val[3]` = result negative, `cr_val[2]` = result positive and `cr_val[1]` = result zero, all taken as a signed 64-bit compare. Exactly one of these three bits is set.
- R9: `cr_val[0]` is the value of `so_in` sampled with the operation that updated the field.
- R10: Synchronous reset drives `res_valid`, `res_data`, `cr_we` and `cr_val` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_a | input | 64 | Addend operand |
| op_b | input | 64 | Operand to be shifted |
| sh_imm | input | 2 | Shift immediate; distance is this value plus one |
| variant | input | 2 | 0 full-width, 1 signed-word, 2 unsigned-word, 3 same as 0 |
| rec_en | input | 1 | Request a condition-field update |
| so_in | input | 1 | Incoming summary-overflow bit |
| res_valid | output | 1 | Registered result valid |
| res_data | output | 64 | Registered result |
| cr_we | output | 1 | Condition-field write enable |
| cr_val | output | 4 | {negative, positive, zero, summary overflow} |

## Verification
The bench builds the unit with its defaults: a 64-bit datapath and a 2-bit immediate. These values make all four shift distances reachable, along with the word boundary at bit 31 where the sign extension decides the upper half. Directed operations cover wrap-around, zero, negative and positive results, and every variant code. Long randomized runs follow, which interleave idle cycles and unrecorded operations, so that the hold behaviour of the result and the condition field is exercised against the reference model.

// File: rtl/shadd_pkg.sv
package shadd_pkg;
  typedef enum logic [1:0] {
    VAR_FULL  = 2'd0,
    VAR_SWORD = 2'd1,
    VAR_UWORD = 2'd2,
    VAR_RSVD  = 2'd3
  } variant_e;

  localparam int CR_W   = 4;
  localparam int CR_LT  = 3;
  localparam int CR_GT  = 2;
  localparam int CR_EQ  = 1;
  localparam int CR_SO  = 0;
endpackage

// File: rtl/shadd_extend.sv
module shadd_extend
  import shadd_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] src,
  input  logic [1:0]      sel,
  output logic [XLEN-1:0] ext
);
  localparam int HALF = XLEN / 2;

  // Word variants keep the low half and widen it; code 3 falls back to full width.
  always_comb begin
    case (variant_e'(sel))
      VAR_SWORD: ext = {{HALF{src[HALF-1]}}, src[HALF-1:0]};
      VAR_UWORD: ext = {{HALF{1'b0}}, src[HALF-1:0]};
      default:   ext = src;
    endcase
  end
endmodule

// File: rtl/shadd_shift_add.sv
module shadd_shift_add #(
  parameter int XLEN = 64,
  parameter int SHW  = 2
) (
  input  logic [XLEN-1:0] shiftee,
  input  logic [XLEN-1:0] addend,
  input  logic [SHW-1:0]  sh,
  output logic [XLEN-1:0] sum
);
  localparam int AMTW = SHW + 1;

  logic [AMTW-1:0] amt;
  logic [XLEN-1:0] shifted;

  // Distance is immediate plus one, so it is never zero.
  assign amt     = {1'b0, sh} + AMTW'(1);
  assign shifted = shiftee << amt;
  assign sum     = shifted + addend;  // carry out discarded
endmodule

// File: rtl/shadd_flags.sv
module shadd_flags
  import shadd_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] val,
  input  logic            so,
  output logic [CR_W-1:0] cr
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (val == '0);
  assign is_neg  = val[XLEN-1];

  always_comb begin
    cr        = '0;
    cr[CR_LT] = is_neg;
    cr[CR_GT] = !is_neg && !is_zero;
    cr[CR_EQ] = is_zero;
    cr[CR_SO] = so;
  end
endmodule

// File: rtl/shadd_unit.sv
module shadd_unit
  import shadd_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int SHW  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [SHW-1:0]  sh_imm,
  input  logic [1:0]      variant,
  input  logic            rec_en,
  input  logic            so_in,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data,
  output logic            cr_we,
  output logic [3:0]      cr_val
);
  logic [XLEN-1:0] b_ext;
  logic [XLEN-1:0] sum_nxt;
  logic [CR_W-1:0] cr_nxt;

  shadd_extend #(.XLEN(XLEN)) u_ext (
    .src (op_b),
    .sel (variant),
    .ext (b_ext)
  );

  shadd_shift_add #(.XLEN(XLEN), .SHW(SHW)) u_sa (
    .shiftee (b_ext),
    .addend  (op_a),
    .sh      (sh_imm),
    .sum     (sum_nxt)
  );

  shadd_flags #(.XLEN(XLEN)) u_fl (
    .val (sum_nxt),
    .so  (so_in),
    .cr  (cr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      cr_we     <= 1'b0;
      cr_val    <= '0;
    end else begin
      res_valid <= in_valid;
      cr_we     <= in_valid && rec_en;
      if (in_valid) res_data <= sum_nxt;
      if (in_valid && rec_en) cr_val <= cr_nxt;
    end
  end

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && $stable(res_data)));
  assert_cr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && rec_en) |=> (!cr_we && $stable(cr_val)));
  assert_cr_with_result_R7: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> res_valid);
  assert_cr_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> ($countones(cr_val[3:1]) == 1));
  assert_cr_sign_R8: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> (cr_val[3] == res_data[XLEN-1] && cr_val[1] == (res_data == '0)));
  assert_so_copy_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rec_en) |=> (cr_val[0] == $past(so_in)));
endmodule

// File: tb/sim_shadd_unit.sv
module sim_shadd_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [1:0]  sh_imm = '0;
  logic [1:0]  variant = '0;
  logic        rec_en = 1'b0;
  logic        so_in = 1'b0;
  logic        res_valid;
  logic [63:0] res_data;
  logic        cr_we;
  logic [3:0]  cr_val;

  int total = 0;
  int bad = 0;

  // reference model state
  logic        m_valid = 1'b0;
  logic [63:0] m_data = '0;
  logic        m_cr_we = 1'b0;
  logic [3:0]  m_cr = '0;
  string       m_tag = "R10";

  always #4 clk = ~clk;

  shadd_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sh_imm(sh_imm), .variant(variant), .rec_en(rec_en), .so_in(so_in),
    .res_valid(res_valid), .res_data(res_data), .cr_we(cr_we), .cr_val(cr_val)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_sum(input logic [63:0] a, input logic [63:0] b,
                                            input int sh, input int vr);
    logic [63:0] bx;
    if (vr == 1)      bx = 64'($signed(b[31:0]));   // R3
    else if (vr == 2) bx = 64'(b[31:0]);            // R4
    else              bx = b;                       // R1, R5
    return (bx << (sh + 1)) + a;                    // R2 wraps
  endfunction

  task automatic compare();
    chk(res_valid == m_valid, "R6 valid", 64'(res_valid), 64'(m_valid));
    chk(res_data == m_data, m_tag, res_data, m_data);
    chk(cr_we == m_cr_we, "R7 cr_we", 64'(cr_we), 64'(m_cr_we));
    chk(cr_val == m_cr, "R8/R9 cr_val", 64'(cr_val), 64'(m_cr));
  endtask

  task automatic step(input bit v, input logic [63:0] a, input logic [63:0] b,
                      input int sh, input int vr, input bit rec, input bit so,
                      input string tag);
    logic [63:0] s;
    @(negedge clk);
    compare();
    in_valid = v; op_a = a; op_b = b; sh_imm = 2'(sh);
    variant = 2'(vr); rec_en = rec; so_in = so;
    m_valid = v;
    m_cr_we = v && rec;
    if (v) begin
      s = model_sum(a, b, sh, vr);
      m_data = s;
      m_tag = tag;
      if (rec) m_cr = {s[63], !s[63] && s != 0, s == 0, so};
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare();                    // R10 reset state
    rst = 1'b0;
    // R1 each shift distance
    for (int i = 0; i < 4; i++)
      step(1, 64'h10, 64'h8000_0000_0000_0003, i, 0, 1, 0, "R1 shift");
    // R2 wrap-around to 1
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, 1, 0, "R2 wrap");
    // R3 sign extension, upper half ignored
    step(1, 64'h0, 64'h1234_5678_8000_0001, 0, 1, 1, 1, "R3 sword neg");
    step(1, 64'h5, 64'hFFFF_FFFF_7000_0000, 3, 1, 1, 0, "R3 sword pos");
    // R4 zero extension
    step(1, 64'h0, 64'h1234_5678_8000_0001, 0, 2, 1, 1, "R4 uword");
    // R5 reserved code
    step(1, 64'h7, 64'hC000_0000_0000_0001, 2, 3, 1, 0, "R5 code3");
    // R8 zero result, R9 so copy
    step(1, 64'h0, 64'h0, 1, 0, 1, 1, "R8 zero");
    // R6 hold across idle, R7 hold across unrecorded op
    step(0, 64'hDEAD, 64'hBEEF, 1, 0, 1, 1, "R6 idle");
    step(1, 64'h1, 64'h2, 0, 0, 0, 1, "R7 norec");
    step(0, 64'h0, 64'h0, 0, 0, 0, 0, "R6 idle");
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] ra, rb;
      int vr;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      vr = int'($urandom_range(0, 3));
      step(($urandom_range(0, 3) != 0), ra, rb, int'($urandom_range(0, 3)), vr,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           vr == 1 ? "R3 rand" : vr == 2 ? "R4 rand" : vr == 3 ? "R5 rand" : "R1 rand");
    end
    step(0, 64'h0, 64'h0, 0, 0, 0, 0, "R6 idle");
    step(0, 64'h0, 64'h0, 0, 0, 0, 0, "R6 idle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule